// File: doc/BRIEF.md
# ADPCM Sample Address Sequencer

This block walks the byte addresses of a 4-bit ADPCM sample stored in an external sample memory and hands the stored nibbles to a decoder one at a time. Software sets three block numbers (the first block of the sample, the final block of the sample and the last block of the memory) and a block-size shift. A block number is turned into a byte address by shifting it left by that amount. A `go` pulse starts playback. The sequencer fetches one byte, delivers its two nibbles with a valid/ready handshake, and then decides where the next byte comes from.

When the current byte is the last byte of the final block, the sample has ended. The block then either returns to idle or restarts from the first block, depending on the repeat bit, and in both cases it sets a sticky end-of-sample flag. When the current byte is the last byte of the memory's final block, and the sample has not ended, the next fetch goes to address zero. In all other cases the address steps up by one. A CPU-fed mode takes each byte from a one-byte data register instead of from memory. In that mode a buffer-ready flag asks software for the next byte.

The control is a five-state machine:
- `S_IDLE` goes to `S_FETCH` on `go` (the address is loaded).
- `S_FETCH` goes to `S_HI` when a byte is captured.
- `S_HI` goes to `S_LO` when the high nibble is accepted.
- `S_LO` goes to `S_ADV` when the low nibble is accepted.
- `S_ADV` goes to `S_IDLE` (sample ended, repeat off) or to `S_FETCH` (repeat restart, wrap to zero, or increment).
- A `halt` pulse sends any state to `S_IDLE`.

Top module: `adpcm_addr_seq`

## Requirements
- R1: On `go` in idle, the first fetch address is `cfg_start << cfg_shift`, so its low `cfg_shift` bits are zero.
- R2: The sample ends only when the current byte address exactly equals `(cfg_stop << cfg_shift) | (2^cfg_shift - 1)`. Addresses above or below that value never end the sample.
- R3: At the sample end with `cfg_loop` = 0, the sequencer returns to idle: `busy` = 0 and no further request is made.
- R4: At the sample end with `cfg_loop` = 1, the next fetch is at the first byte of the start block. `eos` is set at every sample end, whatever the repeat setting.
- R5: When the current address equals `(cfg_limit << cfg_shift) | (2^cfg_shift - 1)` and the sample has not ended, the next fetch address is zero.
- R6: When the end match and the limit match happen on the same byte, the end action is taken. With repeat on, looping works when `cfg_stop` equals `cfg_limit`.
- R7: When neither match happens, the next fetch address is the current address plus one.
- R8: Each byte yields two nibbles on `nib_out`, bits 7:4 first and then bits 3:0. Both are delivered before the next fetch. While `nib_ready` is low, `nib_valid` and `nib_out` hold steady.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. The byte on `mem_data` is captured in the cycle in which `mem_ack` is high.
- R10: With `cfg_cpu_mode` = 1, the sequencer makes no memory request and takes each byte from the last `cpu_data` written with `cpu_wr`. `brdy` rises on `go` and after each byte is taken. A `cpu_wr` or a `clr_brdy` clears it.
- R11: `eos` stays set until `clr_eos` is pulsed. After reset it is zero.
- R12: A limit block of all ones (4095 with the default width) does not overflow. With shift 2, the address after 16383 is 0.
- R13: After reset, and in the cycle after a `halt`, the sequencer is idle with `busy`, `mem_req` and `nib_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | BW | First block of the sample |
| cfg_stop | input | BW | Final block of the sample |
| cfg_limit | input | BW | Last block of sample memory |
| cfg_shift | input | SHW | Block-size shift, clamped to MAX_SH |
| cfg_loop | input | 1 | Restart from the start block at the sample end |
| cfg_cpu_mode | input | 1 | Take bytes from the CPU data register instead of memory |
| go | input | 1 | Start playback pulse (used only when idle) |
| halt | input | 1 | Abort playback pulse |
| clr_eos | input | 1 | Clear the end-of-sample flag |
| clr_brdy | input | 1 | Clear the buffer-ready flag |
| cpu_wr | input | 1 | Write strobe for the CPU data register |
| cpu_data | input | 8 | CPU-written sample byte |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_ack | input | 1 | Read data valid |
| mem_data | input | 8 | Read data |
| nib_out | output | 4 | Current sample nibble |
| nib_valid | output | 1 | Nibble valid |
| nib_ready | input | 1 | Decoder accepts the nibble |
| busy | output | 1 | Playback in progress |
| eos | output | 1 | Sticky end-of-sample flag |
| brdy | output | 1 | Sticky buffer-ready flag (CPU mode) |

## Verification
Properties in the RTL check the following on every cycle:
- the request is held, with a stable address, until it is acknowledged;
- a stalled nibble holds its value;
- the end-of-sample flag is sticky;
- a limit wrap lands on address zero;
- an end with repeat off returns to idle;
- a start loads the start block's first byte.

Only the directed scenarios can show the rest: the full fetch order across restarts and wraps, end priority when stop equals limit, the all-ones limit with a nonzero shift, a start block above the stop block, the nibble order, and the byte-by-byte exchange of the CPU-fed mode.

// File: rtl/adpcm_seq_pkg.sv
`timescale 1ns/1ps
package adpcm_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_HI    = 3'd2,
        S_LO    = 3'd3,
        S_ADV   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/adpcm_blk_addr.sv
`timescale 1ns/1ps
// Converts a block number into the byte address of its first or last byte.
module adpcm_blk_addr #(
    parameter int BW = 12,
    parameter int MAX_SH = 5,
    parameter bit LAST_BYTE = 1'b0,
    localparam int SHW = $clog2(MAX_SH + 1),
    localparam int AW = BW + MAX_SH
) (
    input  logic [BW-1:0]  blk,
    input  logic [SHW-1:0] shift,
    output logic [AW-1:0]  addr
);
    logic [SHW-1:0] s_eff;
    logic [AW-1:0]  base;

    always_comb begin
        s_eff = (int'(shift) > MAX_SH) ? SHW'(MAX_SH) : shift;
        // MAX_SH zero bits of headroom: shifting an all-ones block cannot overflow
        base  = {{MAX_SH{1'b0}}, blk} << s_eff;
    end

    generate
        if (LAST_BYTE) begin : g_last
            always_comb addr = base | ~({AW{1'b1}} << s_eff);
        end else begin : g_first
            always_comb addr = base;
        end
    endgenerate
endmodule

// File: rtl/adpcm_byte_hold.sv
`timescale 1ns/1ps
// Holds the fetched byte and selects the nibble being delivered.
module adpcm_byte_hold #(
    parameter int DW = 8,
    localparam int NW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          sel_lo,
    output logic [NW-1:0] nib
);
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    byte_q <= '0;
        else if (load) byte_q <= din;
    end

    always_comb nib = sel_lo ? byte_q[NW-1:0] : byte_q[DW-1:NW];
endmodule

// File: rtl/adpcm_addr_seq.sv
`timescale 1ns/1ps
module adpcm_addr_seq
    import adpcm_seq_pkg::*;
#(
    parameter int BW = 12,
    parameter int MAX_SH = 5,
    parameter int DW = 8,
    localparam int SHW = $clog2(MAX_SH + 1),
    localparam int AW = BW + MAX_SH,
    localparam int NW = DW / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [BW-1:0]  cfg_start,
    input  logic [BW-1:0]  cfg_stop,
    input  logic [BW-1:0]  cfg_limit,
    input  logic [SHW-1:0] cfg_shift,
    input  logic           cfg_loop,
    input  logic           cfg_cpu_mode,
    input  logic           go,
    input  logic           halt,
    input  logic           clr_eos,
    input  logic           clr_brdy,
    input  logic           cpu_wr,
    input  logic [DW-1:0]  cpu_data,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_data,
    output logic [NW-1:0]  nib_out,
    output logic           nib_valid,
    input  logic           nib_ready,
    output logic           busy,
    output logic           eos,
    output logic           brdy
);
    seq_state_t    state, state_n;
    logic [AW-1:0] cur_addr, cur_addr_n;
    logic          mode_q;
    logic [AW-1:0] start_addr, stop_last, lim_last;
    logic          end_hit, lim_hit;
    logic [DW-1:0] cbuf;
    logic          cbuf_full;
    logic          take_mem, take_cpu, byte_load;
    logic [DW-1:0] byte_in;
    logic          brdy_set, brdy_clr;

    // block-to-byte address converters
    adpcm_blk_addr #(.BW(BW), .MAX_SH(MAX_SH), .LAST_BYTE(1'b0)) u_start (
        .blk(cfg_start), .shift(cfg_shift), .addr(start_addr));
    adpcm_blk_addr #(.BW(BW), .MAX_SH(MAX_SH), .LAST_BYTE(1'b1)) u_stop (
        .blk(cfg_stop), .shift(cfg_shift), .addr(stop_last));
    adpcm_blk_addr #(.BW(BW), .MAX_SH(MAX_SH), .LAST_BYTE(1'b1)) u_limit (
        .blk(cfg_limit), .shift(cfg_shift), .addr(lim_last));

    always_comb begin
        end_hit   = (cur_addr == stop_last);
        lim_hit   = (cur_addr == lim_last);
        take_mem  = (state == S_FETCH) && !mode_q && mem_ack;
        take_cpu  = (state == S_FETCH) && mode_q && cbuf_full;
        byte_load = take_mem || take_cpu;
        byte_in   = mode_q ? cbuf : mem_data;
    end

    adpcm_byte_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(byte_load), .din(byte_in),
        .sel_lo(state == S_LO), .nib(nib_out));

    // next-state and next-address
    always_comb begin
        state_n    = state;
        cur_addr_n = cur_addr;
        unique case (state)
            S_IDLE: if (go) begin
                state_n    = S_FETCH;
                cur_addr_n = start_addr;
            end
            S_FETCH: if (byte_load) state_n = S_HI;
            S_HI:    if (nib_ready) state_n = S_LO;
            S_LO:    if (nib_ready) state_n = S_ADV;
            S_ADV: begin
                // end check ranks above limit check
                if (end_hit) begin
                    if (cfg_loop) begin
                        state_n    = S_FETCH;
                        cur_addr_n = start_addr;
                    end else begin
                        state_n = S_IDLE;
                    end
                end else if (lim_hit) begin
                    state_n    = S_FETCH;
                    cur_addr_n = '0;
                end else begin
                    state_n    = S_FETCH;
                    cur_addr_n = cur_addr + 1'b1;
                end
            end
            default: state_n = S_IDLE;
        endcase
        if (halt) state_n = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            mode_q   <= 1'b0;
        end else begin
            state    <= state_n;
            cur_addr <= cur_addr_n;
            if (state == S_IDLE && go) mode_q <= cfg_cpu_mode;
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state == S_FETCH) && !mode_q;
        mem_addr  = cur_addr;
        nib_valid = (state == S_HI) || (state == S_LO);
        busy      = (state != S_IDLE);
        brdy_set  = ((state == S_IDLE) && go && cfg_cpu_mode) || take_cpu;
        brdy_clr  = cpu_wr || clr_brdy;
    end

    // sticky status and CPU data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eos       <= 1'b0;
            brdy      <= 1'b0;
            cbuf      <= '0;
            cbuf_full <= 1'b0;
        end else begin
            if ((state == S_ADV) && end_hit) eos <= 1'b1;
            else if (clr_eos)                eos <= 1'b0;
            brdy <= (brdy || brdy_set) && !brdy_clr;
            if (cpu_wr) begin
                cbuf      <= cpu_data;
                cbuf_full <= 1'b1;
            end else if (take_cpu) begin
                cbuf_full <= 1'b0;
            end
        end
    end

    // R1 start address
    a_r1_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && go && !halt) |=> (mem_addr == $past(start_addr)));
    // R3 stop without repeat
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADV && end_hit && !cfg_loop) |=> !busy);
    // R4 end always flags
    a_r4_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADV && end_hit) |=> eos);
    // R5 limit wrap
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADV && lim_hit && !end_hit && !halt) |=> (mem_addr == '0));
    // R8 nibble stall
    a_r8_nib_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid && !nib_ready && !halt) |=> (nib_valid && $stable(nib_out)));
    // R9 request hold
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr)));
    // R11 sticky flag
    a_r11_eos_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !clr_eos) |=> eos);
endmodule

// File: tb/sim_adpcm_addr_seq.sv
`timescale 1ns/1ps
module sim_adpcm_addr_seq;
    localparam int BW = 12;
    localparam int MAX_SH = 5;
    localparam int SHW = $clog2(MAX_SH + 1);
    localparam int AW = BW + MAX_SH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BW-1:0] cfg_start = '0, cfg_stop = '0, cfg_limit = '1;
    logic [SHW-1:0] cfg_shift = '0;
    logic cfg_loop = 1'b0, cfg_cpu_mode = 1'b0;
    logic go = 1'b0, halt = 1'b0, clr_eos = 1'b0, clr_brdy = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_data = '0;
    logic mem_req, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_data;
    logic [3:0] nib_out;
    logic nib_valid, nib_ready = 1'b1;
    logic busy, eos, brdy;

    int nchk = 0, nfail = 0;
    logic [AW-1:0] flog [0:63];
    logic [3:0]    nlog [0:127];
    logic [AW-1:0] ex   [0:63];
    int fcnt = 0, ncnt = 0;

    always #2.5 clk = ~clk;

    adpcm_addr_seq #(.BW(BW), .MAX_SH(MAX_SH), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
        .cfg_limit(cfg_limit), .cfg_shift(cfg_shift), .cfg_loop(cfg_loop),
        .cfg_cpu_mode(cfg_cpu_mode), .go(go), .halt(halt), .clr_eos(clr_eos),
        .clr_brdy(clr_brdy), .cpu_wr(cpu_wr), .cpu_data(cpu_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_data(mem_data), .nib_out(nib_out), .nib_valid(nib_valid),
        .nib_ready(nib_ready), .busy(busy), .eos(eos), .brdy(brdy));

    // sample memory: one-cycle latency, data derived from address
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            mem_data <= '0;
        end else begin
            mem_ack  <= mem_req && !mem_ack;
            mem_data <= mem_addr[7:0] ^ 8'h5A;
        end
    end

    // monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack && fcnt < 64) begin
                flog[fcnt] = mem_addr;
                fcnt = fcnt + 1;
            end
            if (nib_valid && nib_ready && ncnt < 128) begin
                nlog[ncnt] = nib_out;
                ncnt = ncnt + 1;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_go();
        go = 1'b1; tick(); go = 1'b0;
    endtask

    task automatic wait_idle(input int maxc);
        for (int i = 0; i < maxc && busy; i++) tick();
    endtask

    task automatic prep();
        clr_eos = 1'b1; clr_brdy = 1'b1; tick();
        clr_eos = 1'b0; clr_brdy = 1'b0;
        fcnt = 0; ncnt = 0;
    endtask

    task automatic chk_fetch(input string req, input int n, input bit exact);
        bit ok = exact ? (fcnt == n) : (fcnt >= n);
        check(ok, req, "fetch count", fcnt, n);
        for (int i = 0; i < n; i++)
            if (i < fcnt) check(flog[i] == ex[i], req, $sformatf("fetch %0d addr", i), flog[i], ex[i]);
    endtask

    task automatic t_reset();
        check(!busy && !mem_req && !nib_valid, "R13", "idle after reset", busy, 0);
        check(!eos && !brdy, "R11", "flags after reset", {eos, brdy}, 0);
    endtask

    task automatic t_basic();   // R1 R3 R7 R8
        prep();
        cfg_start = 2; cfg_stop = 3; cfg_limit = '1; cfg_shift = 2; cfg_loop = 0; cfg_cpu_mode = 0;
        pulse_go();
        wait_idle(400);
        for (int i = 0; i < 8; i++) ex[i] = AW'(8 + i);
        chk_fetch("R7", 8, 1'b1);
        check(!busy && eos, "R3", "idle with eos", {busy, eos}, 1);
        begin
            bit ok = (ncnt == 16);
            for (int i = 0; i < 8 && ok; i++) begin
                logic [7:0] d = 8'(8 + i) ^ 8'h5A;
                ok = (nlog[2*i] == d[7:4]) && (nlog[2*i+1] == d[3:0]);
            end
            check(ok, "R8", "nibble order", ncnt, 16);
        end
        clr_eos = 1'b1; tick(); clr_eos = 1'b0;
        check(!eos, "R11", "eos cleared", eos, 0);
    endtask

    task automatic t_loop_same();   // R4 R6
        prep();
        cfg_start = 1; cfg_stop = 2; cfg_limit = 2; cfg_shift = 1; cfg_loop = 1;
        pulse_go();
        for (int i = 0; i < 400 && fcnt < 10; i++) tick();
        halt = 1'b1; tick(); halt = 1'b0;
        check(!busy && !mem_req && !nib_valid, "R13", "idle after halt", busy, 0);
        for (int i = 0; i < 10; i++) ex[i] = AW'(2 + (i % 4));
        chk_fetch("R6", 10, 1'b0);
        check(eos, "R4", "eos with repeat", eos, 1);
    endtask

    task automatic t_wrap();   // R2 R5
        prep();
        cfg_start = 3; cfg_stop = 1; cfg_limit = 4; cfg_shift = 1; cfg_loop = 0;
        pulse_go();
        wait_idle(400);
        ex[0] = 6; ex[1] = 7; ex[2] = 8; ex[3] = 9;
        ex[4] = 0; ex[5] = 1; ex[6] = 2; ex[7] = 3;
        chk_fetch("R5", 8, 1'b1);
        check(eos && !busy, "R2", "end after wrap only", {eos, busy}, 2);
    endtask

    task automatic t_limit_max();   // R12
        prep();
        cfg_start = 12'hFFF; cfg_stop = 0; cfg_limit = 12'hFFF; cfg_shift = 2; cfg_loop = 0;
        pulse_go();
        wait_idle(400);
        for (int i = 0; i < 4; i++) ex[i] = AW'(16380 + i);
        for (int i = 0; i < 4; i++) ex[4 + i] = AW'(i);
        chk_fetch("R12", 8, 1'b1);
    endtask

    task automatic t_stall();   // R8 R9
        prep();
        cfg_start = 5; cfg_stop = 5; cfg_limit = '1; cfg_shift = 0; cfg_loop = 0;
        nib_ready = 1'b0;
        pulse_go();
        for (int i = 0; i < 8; i++) tick();
        check(nib_valid && nib_out == 4'h5, "R8", "stalled high nibble", nib_out, 5);
        check(fcnt == 1 && !mem_req, "R9", "single fetch while stalled", fcnt, 1);
        nib_ready = 1'b1;
        wait_idle(100);
        check(ncnt == 2 && nlog[0] == 4'h5 && nlog[1] == 4'hF, "R8", "nibbles after stall", ncnt, 2);
    endtask

    task automatic t_cpu();   // R10
        prep();
        cfg_start = 0; cfg_stop = 0; cfg_limit = '1; cfg_shift = 1; cfg_loop = 0; cfg_cpu_mode = 1;
        pulse_go();
        check(brdy && !mem_req && busy, "R10", "brdy on go", brdy, 1);
        cpu_data = 8'hA5; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
        check(!brdy, "R10", "brdy cleared by write", brdy, 0);
        for (int i = 0; i < 20 && !brdy; i++) tick();
        check(brdy, "R10", "brdy after take", brdy, 1);
        cpu_data = 8'h3C; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
        wait_idle(100);
        check(ncnt == 4 && nlog[0] == 4'hA && nlog[1] == 4'h5 && nlog[2] == 4'h3 && nlog[3] == 4'hC,
              "R10", "cpu nibbles", ncnt, 4);
        check(fcnt == 0 && eos, "R10", "no memory fetch, eos", fcnt, 0);
        clr_brdy = 1'b1; tick(); clr_brdy = 1'b0;
        check(!brdy, "R10", "clr_brdy", brdy, 0);
        cfg_cpu_mode = 0;
    endtask

    task automatic t_halt();   // R13
        prep();
        cfg_start = 0; cfg_stop = 100; cfg_limit = '1; cfg_shift = 2; cfg_loop = 0;
        pulse_go();
        for (int i = 0; i < 20; i++) tick();
        halt = 1'b1; tick(); halt = 1'b0;
        check(!busy && !mem_req && !nib_valid && !eos, "R13", "halt mid-sample", busy, 0);
    endtask

    initial begin
        #200_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_loop_same();
        t_wrap();
        t_limit_max();
        t_stall();
        t_cpu();
        t_halt();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule